// File: doc/BRIEF.md
# Downward Stack Pointer Unit

This block keeps the stack pointer of a small 8-bit processor. The stack grows toward lower addresses. Each cycle the core may present one stack operation: a one-byte data push or pop, or a two-byte return-address push or pop. The unit gives the data memory the address to use, whether the access is a write, and which byte of a return address is moving. It then moves the pointer by one for each byte transferred. Software can read and load the pointer as two 8-bit I/O registers, a low byte and a high byte.

A push writes at the current pointer and then decrements it. A pop increments the pointer first and then reads. A two-byte transfer takes two consecutive cycles. The low byte of a return address sits at the higher address, so a push stores the low byte first and a pop reads the high byte first. Software must load the pointer before the first call or interrupt, to a value above 0x0100 when the high byte is implemented.

The parameter `SP_BITS` (8 to 16) sets how many pointer bits exist. With `SP_BITS = 8` only the low byte is built and the high-byte register reads as absent. The sequencer is a three-state machine:
- `ST_IDLE`: accepts a new operation or an I/O load.
- `ST_PUSH_SECOND`: second write of a return-address push.
- `ST_POP_SECOND`: second read of a return-address pop.

Its transitions are:
- `ST_IDLE` to `ST_PUSH_SECOND` on a return push with no I/O load.
- `ST_IDLE` to `ST_POP_SECOND` on a return pop with no I/O load.
- `ST_PUSH_SECOND` to `ST_IDLE` and `ST_POP_SECOND` to `ST_IDLE` unconditionally.
- `ST_IDLE` to `ST_IDLE` otherwise.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer holds all ones in its implemented bits, the unit is idle (`busy` = 0), and no memory access is requested.
- R2: Operation code 1 (data push) in an idle cycle requests a write at the current pointer with `mem_ret_hi` = 0, and the pointer is one lower on the next cycle.
- R3: Operation code 2 (data pop) in an idle cycle requests a read at pointer+1 with `mem_ret_hi` = 0, and the pointer is one higher on the next cycle.
- R4: Operation code 3 (return push) gives two consecutive write cycles. The first is at the pointer with `mem_ret_hi` = 0. The second is at pointer−1 with `mem_ret_hi` = 1 and `busy` = 1. The pointer ends two lower.
- R5: Operation code 4 (return pop) gives two consecutive read cycles. The first is at pointer+1 with `mem_ret_hi` = 1. The second is at pointer+2 with `mem_ret_hi` = 0 and `busy` = 1. The pointer ends two higher.
- R6: While `busy` is 1, the operation input is ignored. Codes 0, 5, 6 and 7 request no access and leave the pointer unchanged.
- R7: `io_wr_lo` loads `io_wdata` into pointer bits 7:0 and `io_wr_hi` loads it into bits above 7. `io_rd_lo` and `io_rd_hi` always show the current pointer.
- R8: An I/O load in an idle cycle takes precedence: any operation in that cycle is dropped with no access. An I/O load in a `busy` cycle is ignored.
- R9: Pointer bits at or above `SP_BITS` read as zero and ignore loads. `hi_present` is 1 only when `SP_BITS` > 8.
- R10: Pointer arithmetic wraps modulo 2^`SP_BITS`. A push at zero leaves all ones, and a pop at all ones reads address zero and leaves zero.
- R11: `mem_addr` bits at or above `SP_BITS` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stk_op | input | 3 | Stack operation code (0 none, 1 data push, 2 data pop, 3 return push, 4 return pop) |
| io_wr_lo | input | 1 | Load pointer low byte |
| io_wr_hi | input | 1 | Load pointer high byte |
| io_wdata | input | 8 | Byte value for an I/O load |
| io_rd_lo | output | 8 | Pointer low byte |
| io_rd_hi | output | 8 | Pointer high byte, zero when absent |
| hi_present | output | 1 | High byte is implemented |
| mem_addr | output | 16 | Stack memory address |
| mem_valid | output | 1 | Memory access requested this cycle |
| mem_write | output | 1 | Access is a write (push) |
| mem_ret_hi | output | 1 | Access carries the high byte of a return address |
| busy | output | 1 | Second cycle of a two-byte transfer |

## Verification
The assertions treat the two readback ports together as the pointer. They take for granted that every cycle with an access is followed by exactly one pointer step in the matching direction, so they rely on the unit itself refusing I/O loads during access cycles. The random stimulus deliberately puts I/O loads on the same cycles as operations and on `busy` cycles, which exercises that refusal. It also issues the unused codes 5 to 7. Directed cases load the pointer to zero and to all ones so that wrapping and the upper-bit masking are reached in both a 12-bit and an 8-bit build.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    // Operation codes presented by the core
    localparam logic [2:0] OP_NONE      = 3'd0;
    localparam logic [2:0] OP_PUSH_DATA = 3'd1;
    localparam logic [2:0] OP_POP_DATA  = 3'd2;
    localparam logic [2:0] OP_PUSH_RET  = 3'd3;
    localparam logic [2:0] OP_POP_RET   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PUSH_SECOND = 2'd1,
        ST_POP_SECOND  = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_DEC  = 2'd1,
        ADJ_INC  = 2'd2
    } adj_e;
endpackage

// File: rtl/sp_fsm.sv
module sp_fsm
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op,
    input  logic       io_req,
    output adj_e       adj,
    output logic       addr_plus1,
    output logic       mem_valid,
    output logic       mem_write,
    output logic       mem_hi,
    output logic       busy
);
    stk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!io_req) begin
                    if (op == OP_PUSH_RET)     state_d = ST_PUSH_SECOND;
                    else if (op == OP_POP_RET) state_d = ST_POP_SECOND;
                end
            end
            ST_PUSH_SECOND: state_d = ST_IDLE;
            ST_POP_SECOND:  state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        adj        = ADJ_HOLD;
        addr_plus1 = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_hi     = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!io_req) begin
                    case (op)
                        OP_PUSH_DATA, OP_PUSH_RET: begin
                            adj       = ADJ_DEC;
                            mem_valid = 1'b1;
                            mem_write = 1'b1;
                        end
                        OP_POP_DATA: begin
                            adj        = ADJ_INC;
                            addr_plus1 = 1'b1;
                            mem_valid  = 1'b1;
                        end
                        OP_POP_RET: begin
                            adj        = ADJ_INC;
                            addr_plus1 = 1'b1;
                            mem_valid  = 1'b1;
                            mem_hi     = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUSH_SECOND: begin
                adj       = ADJ_DEC;
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_hi    = 1'b1;
                busy      = 1'b1;
            end
            ST_POP_SECOND: begin
                adj        = ADJ_INC;
                addr_plus1 = 1'b1;
                mem_valid  = 1'b1;
                busy       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
    import sp_pkg::*;
#(
    parameter int SP_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  adj_e               adj,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [SP_BITS-1:0] sp
);
    localparam logic [SP_BITS-1:0] ONE = SP_BITS'(1);

    logic [SP_BITS-1:0] sp_q;
    logic [SP_BITS-1:0] loaded;

    generate
        if (SP_BITS > BYTE_W) begin : g_two_bytes
            always_comb begin
                loaded = sp_q;
                if (wr_lo) loaded[BYTE_W-1:0] = wdata;
                if (wr_hi) loaded[SP_BITS-1:BYTE_W] = wdata[SP_BITS-BYTE_W-1:0];
            end
        end else begin : g_low_only
            logic unused_hi;
            assign unused_hi = wr_hi;
            always_comb begin
                loaded = sp_q;
                if (wr_lo) loaded = wdata[SP_BITS-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '1;
        end else if (wr_lo || wr_hi) begin
            sp_q <= loaded;
        end else begin
            case (adj)
                ADJ_DEC: sp_q <= sp_q - ONE;
                ADJ_INC: sp_q <= sp_q + ONE;
                default: ;
            endcase
        end
    end

    assign sp = sp_q;
endmodule

// File: rtl/sp_view.sv
module sp_view
    import sp_pkg::*;
#(
    parameter int SP_BITS = 12
) (
    input  logic [SP_BITS-1:0] sp,
    input  logic               addr_plus1,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  rd_lo,
    output logic [BYTE_W-1:0]  rd_hi,
    output logic               hi_present
);
    localparam logic [SP_BITS-1:0] ONE = SP_BITS'(1);

    logic [SP_BITS-1:0] sp_next;
    assign sp_next  = sp + ONE;
    assign mem_addr = ADDR_W'(addr_plus1 ? sp_next : sp);
    assign rd_lo    = sp[BYTE_W-1:0];

    generate
        if (SP_BITS > BYTE_W) begin : g_hi
            assign rd_hi      = BYTE_W'(sp[SP_BITS-1:BYTE_W]);
            assign hi_present = 1'b1;
        end else begin : g_no_hi
            assign rd_hi      = '0;
            assign hi_present = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sp_unit.sv
module sp_unit
    import sp_pkg::*;
#(
    parameter int SP_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  stk_op,
    input  logic        io_wr_lo,
    input  logic        io_wr_hi,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rd_lo,
    output logic [7:0]  io_rd_hi,
    output logic        hi_present,
    output logic [15:0] mem_addr,
    output logic        mem_valid,
    output logic        mem_write,
    output logic        mem_ret_hi,
    output logic        busy
);
    adj_e               adj;
    logic               addr_plus1;
    logic               io_req;
    logic               wr_lo_g;
    logic               wr_hi_g;
    logic [SP_BITS-1:0] sp;

    assign io_req  = io_wr_lo | io_wr_hi;
    assign wr_lo_g = io_wr_lo & ~busy;
    assign wr_hi_g = io_wr_hi & ~busy;

    sp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (stk_op),
        .io_req     (io_req),
        .adj        (adj),
        .addr_plus1 (addr_plus1),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_hi     (mem_ret_hi),
        .busy       (busy)
    );

    sp_ptr_reg #(.SP_BITS(SP_BITS)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adj   (adj),
        .wr_lo (wr_lo_g),
        .wr_hi (wr_hi_g),
        .wdata (io_wdata),
        .sp    (sp)
    );

    sp_view #(.SP_BITS(SP_BITS)) u_view (
        .sp         (sp),
        .addr_plus1 (addr_plus1),
        .mem_addr   (mem_addr),
        .rd_lo      (io_rd_lo),
        .rd_hi      (io_rd_hi),
        .hi_present (hi_present)
    );
endmodule

// File: rtl/sp_unit_checker.sv
module sp_unit_checker #(
    parameter int SP_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  io_rd_lo,
    input logic [7:0]  io_rd_hi,
    input logic        hi_present,
    input logic [15:0] mem_addr,
    input logic        mem_valid,
    input logic        mem_write,
    input logic        mem_ret_hi,
    input logic        busy
);
    localparam logic [15:0] MASK = 16'((32'd1 << SP_BITS) - 1);

    logic [15:0] sp_view;
    assign sp_view = {io_rd_hi, io_rd_lo};

    // R2 R4: writes land at the pointer
    assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_addr == sp_view);
    // R3 R5: reads land one above the pointer
    assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_write |-> mem_addr == ((sp_view + 16'd1) & MASK));
    // R2 R10: a write access lowers the pointer by one, wrapping
    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |=> sp_view == (($past(sp_view) - 16'd1) & MASK));
    // R3 R10: a read access raises the pointer by one, wrapping
    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_write |=> sp_view == (($past(sp_view) + 16'd1) & MASK));
    // R4 R5: a busy cycle always carries an access
    assert_busy_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_valid);
    // R6: busy never lasts two cycles and follows an access
    assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R4: second push cycle carries the high byte
    assert_push_second_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_write |-> mem_ret_hi);
    // R5: second pop cycle carries the low byte
    assert_pop_second_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_write |-> !mem_ret_hi);
    // R9: absent high byte reads zero
    assert_hi_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_present |-> io_rd_hi == 8'd0);
    // R11: no address bits above the implemented width
    assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr & ~MASK) == 16'd0);
endmodule

bind sp_unit sp_unit_checker #(.SP_BITS(SP_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_rd_lo   (io_rd_lo),
    .io_rd_hi   (io_rd_hi),
    .hi_present (hi_present),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_ret_hi (mem_ret_hi),
    .busy       (busy)
);

// File: tb/sp_unit_bench.sv
module sp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  stk_op = 3'd0;
    logic        io_wr_lo = 1'b0;
    logic        io_wr_hi = 1'b0;
    logic [7:0]  io_wdata = 8'd0;

    logic [7:0]  a_lo, a_hi, b_lo, b_hi;
    logic        a_pres, b_pres, a_v, b_v, a_w, b_w, a_h, b_h, a_b, b_b;
    logic [15:0] a_addr, b_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state: 0 idle, 1 second push, 2 second pop
    int          mstate = 0;
    logic [15:0] sp_a = 16'h0FFF;
    logic [15:0] sp_b = 16'h00FF;
    localparam logic [15:0] MASK_A = 16'h0FFF;
    localparam logic [15:0] MASK_B = 16'h00FF;

    always #2 clk = ~clk;

    sp_unit #(.SP_BITS(12)) u_sp_unit (
        .clk(clk), .rst_n(rst_n), .stk_op(stk_op), .io_wr_lo(io_wr_lo),
        .io_wr_hi(io_wr_hi), .io_wdata(io_wdata), .io_rd_lo(a_lo), .io_rd_hi(a_hi),
        .hi_present(a_pres), .mem_addr(a_addr), .mem_valid(a_v), .mem_write(a_w),
        .mem_ret_hi(a_h), .busy(a_b)
    );

    sp_unit #(.SP_BITS(8)) u_sp_unit_narrow (
        .clk(clk), .rst_n(rst_n), .stk_op(stk_op), .io_wr_lo(io_wr_lo),
        .io_wr_hi(io_wr_hi), .io_wdata(io_wdata), .io_rd_lo(b_lo), .io_rd_hi(b_hi),
        .hi_present(b_pres), .mem_addr(b_addr), .mem_valid(b_v), .mem_write(b_w),
        .mem_ret_hi(b_h), .busy(b_b)
    );

    // expected packed outputs {valid,write,ret_hi,busy,addr,lo,hi,present}
    function automatic logic [36:0] expect_out(input int st, input logic [15:0] sp,
                                                input logic [15:0] mask, input logic [2:0] op,
                                                input logic wl, input logic wh);
        logic v = 0, w = 0, h = 0, b = 0;
        logic [15:0] ad = sp;
        if (st == 1) begin v = 1; w = 1; h = 1; b = 1; end
        else if (st == 2) begin v = 1; b = 1; ad = (sp + 16'd1) & mask; end
        else if (!(wl || wh)) begin
            case (op)
                3'd1, 3'd3: begin v = 1; w = 1; end
                3'd2: begin v = 1; ad = (sp + 16'd1) & mask; end
                3'd4: begin v = 1; h = 1; ad = (sp + 16'd1) & mask; end
                default: ;
            endcase
        end
        return {v, w, h, b, ad, sp[7:0], sp[15:8], (mask > 16'h00FF)};
    endfunction

    function automatic logic [15:0] next_sp(input int st, input logic [15:0] sp,
                                            input logic [15:0] mask, input logic [2:0] op,
                                            input logic wl, input logic wh, input logic [7:0] d);
        logic [15:0] r = sp;
        if (st == 1) r = sp - 16'd1;
        else if (st == 2) r = sp + 16'd1;
        else if (wl || wh) begin
            if (wl) r[7:0] = d;
            if (wh) r[15:8] = d;
        end else begin
            case (op)
                3'd1, 3'd3: r = sp - 16'd1;
                3'd2, 3'd4: r = sp + 16'd1;
                default: ;
            endcase
        end
        return r & mask;
    endfunction

    function automatic string tag_of(input int st, input logic [2:0] op,
                                     input logic wl, input logic wh);
        if (st == 1) return (wl || wh || op != 0) ? "R6/R8 (R4)" : "R4";
        if (st == 2) return (wl || wh || op != 0) ? "R6/R8 (R5)" : "R5";
        if (wl || wh) return "R7/R8/R9";
        case (op)
            3'd1: return "R2/R10/R11";
            3'd2: return "R3/R10/R11";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp,
                         input string who);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, who, got, exp);
        end
    endtask

    // one cycle: drive at negedge, sample 1 ns later, advance model at posedge
    task automatic step(input logic [2:0] op, input logic wl, input logic wh,
                        input logic [7:0] d);
        @(negedge clk);
        stk_op = op; io_wr_lo = wl; io_wr_hi = wh; io_wdata = d;
        #1;
        check(tag_of(mstate, op, wl, wh),
              {a_v, a_w, a_h, a_b, a_addr, a_lo, a_hi, a_pres},
              expect_out(mstate, sp_a, MASK_A, op, wl, wh), "wide");
        check(tag_of(mstate, op, wl, wh),
              {b_v, b_w, b_h, b_b, b_addr, b_lo, b_hi, b_pres},
              expect_out(mstate, sp_b, MASK_B, op, wl, wh), "narrow");
        @(posedge clk);
        sp_a = next_sp(mstate, sp_a, MASK_A, op, wl, wh, d);
        sp_b = next_sp(mstate, sp_b, MASK_B, op, wl, wh, d);
        if (mstate != 0) mstate = 0;
        else if (!(wl || wh) && op == 3'd3) mstate = 1;
        else if (!(wl || wh) && op == 3'd4) mstate = 2;
    endtask

    task automatic load(input logic [15:0] v);
        step(3'd0, 1'b1, 1'b1, v[7:0]);
        step(3'd0, 1'b0, 1'b1, v[15:8]);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset values
        check("R1", {a_v, a_w, a_h, a_b, a_addr, a_lo, a_hi, a_pres},
              {1'b0, 1'b0, 1'b0, 1'b0, 16'h0FFF, 8'hFF, 8'h0F, 1'b1}, "wide");
        check("R1", {b_v, b_w, b_h, b_b, b_addr, b_lo, b_hi, b_pres},
              {1'b0, 1'b0, 1'b0, 1'b0, 16'h00FF, 8'hFF, 8'h00, 1'b0}, "narrow");
        rst_n = 1'b1;

        // R7 R9: load and read back, upper bits masked
        load(16'hFF40);
        step(3'd0, 1'b0, 1'b0, 8'h00);
        // R2 R3 R4 R5 basic sequences
        step(3'd1, 1'b0, 1'b0, 8'h00);
        step(3'd3, 1'b0, 1'b0, 8'h00);
        step(3'd0, 1'b0, 1'b0, 8'h00);
        step(3'd4, 1'b0, 1'b0, 8'h00);
        step(3'd0, 1'b0, 1'b0, 8'h00);
        step(3'd2, 1'b0, 1'b0, 8'h00);
        // R6: op during busy cycle ignored, unused codes
        step(3'd3, 1'b0, 1'b0, 8'h00);
        step(3'd1, 1'b0, 1'b0, 8'h00);
        step(3'd7, 1'b0, 1'b0, 8'h00);
        step(3'd5, 1'b0, 1'b0, 8'h00);
        // R8: load during busy ignored, load beats op in idle
        step(3'd4, 1'b0, 1'b0, 8'h00);
        step(3'd0, 1'b1, 1'b1, 8'h55);
        step(3'd3, 1'b1, 1'b0, 8'h22);
        step(3'd0, 1'b0, 1'b0, 8'h00);
        // R10: wrap at zero and at all ones
        load(16'h0000);
        step(3'd1, 1'b0, 1'b0, 8'h00);
        step(3'd2, 1'b0, 1'b0, 8'h00);
        step(3'd4, 1'b0, 1'b0, 8'h00);
        step(3'd0, 1'b0, 1'b0, 8'h00);
        load(16'h0001);
        step(3'd3, 1'b0, 1'b0, 8'h00);
        step(3'd0, 1'b0, 1'b0, 8'h00);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op = 3'($urandom % 8);
            logic wl = ($urandom % 10) == 0;
            logic wh = ($urandom % 12) == 0;
            logic [7:0] d = 8'($urandom);
            if (op > 3'd4 && ($urandom % 2) == 0) op = 3'($urandom % 5);
            step(op, wl, wh, d);
        end
        step(3'd0, 1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule